// File: doc/BRIEF.md
# Root Hub Downstream Port Status Controller

This block holds the status and change word for one downstream port of a USB host controller's root hub. It follows the device-side levels (attach, low-speed device, port power, over-current) and hardware pulses (loss of enable, remote resume request). It also acts on host software writes to the same word. Writes of 1 to chosen low bits start a port reset, suspend the port, resume it, set enable or clear enable. Writes of 1 to the upper bits clear sticky change flags.

A shared millisecond tick, derived from a clock-count parameter, drives two timed sequences. The first is a port reset of ten ticks. The second is a resume made of a twenty-tick pulse, a one-tick low-speed end-of-packet phase and a three-tick resynchronization delay. The tick counter restarts whenever a sequence starts, so each completion lands a fixed number of clock cycles after the start. Every change flag is also driven on its own output wire, for use by the host controller's interrupt logic.

Top module: `rhp_port_status`

## Requirements
- R1: After reset, with all inputs low, the status word reads 0 and every change-flag output is 0.
- R2: Bits 31..21, 15..10 and 7..5 of the status word always read 0.
- R3: A write with a 1 in a change-flag position (connect 16, enable 17, suspend 18, over-current 19, reset 20) clears that flag one cycle later. A 0 in that position leaves the flag as it was.
- R4: Bit 0 (connected) follows the attach input one cycle late. Bit 16 sets in that same cycle whenever bit 0 changes. Bit 9 (low-speed) shows the low-speed input while attached. Bit 8 shows port power one cycle late.
- R5: A write of 1 to bit 4 starts a port reset. Bit 4 reads 1 from the next cycle for 10×CLKS_PER_MS−1 cycles. In cycle 10×CLKS_PER_MS after the write, bit 4 clears, bit 20 sets, bit 1 (enabled) sets and bit 2 (suspended) clears.
- R6: Reset, suspend and resume starts are ignored unless the port is both connected (bit 0) and powered (bit 8).
- R7: A write of 1 to bit 2 while enabled sets bit 2 one cycle later.
- R8: While suspended, a write of 1 to bit 3 or a resume-request pulse starts a resume. Bit 2 stays 1 through cycle 24×CLKS_PER_MS−1 after the start. In cycle 24×CLKS_PER_MS, bit 2 clears and bit 18 sets.
- R9: Bit 18 is cleared in the cycle in which bit 20 becomes set.
- R10: Bit 17 sets only when hardware clears enable: the enable-loss pulse, or detach, while enabled. A write of 1 to bit 0 clears enable, and a write of 1 to bit 1 sets enable while connected. Neither write sets bit 17.
- R11: Bit 3 follows the over-current input one cycle late. Bit 19 sets whenever bit 3 changes, provided per-port over-current reporting is enabled.
- R12: When a flag's set event and a write-1 clear of that flag fall in the same cycle, the flag ends up set.
- R13: The change-flag output holds connect, enable, suspend, over-current and reset changes at indices 0 to 4, equal to status bits 16 to 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| dev_connect_i | input | 1 | Device attached level |
| dev_low_speed_i | input | 1 | Attached device is low speed |
| port_power_i | input | 1 | Port power is on |
| over_current_i | input | 1 | Over-current level for this port |
| en_loss_i | input | 1 | Hardware enable-loss pulse |
| resume_req_i | input | 1 | Remote resume request pulse |
| status_o | output | 32 | Status and change word |
| chg_o | output | 5 | Change flags, one per wire |

## Verification
Every level, write and pulse is sampled at a single clock edge. Its direct effects (status bits, flags, enable) show from the next cycle on. A reset completes exactly 10×CLKS_PER_MS cycles after the write edge, and a resume completes 24×CLKS_PER_MS cycles after its start edge, because the tick counter restarts when a sequence starts. The bench records the edge at which each stimulus is taken. It queues each expected value against a due cycle counted from that edge. At the due cycle it compares the outputs, half a period after the edge. It also checks the cycle just before each completion, to catch an off-by-one tick.

// File: rtl/rhp_pkg.sv
package rhp_pkg;
  localparam int CCS_B  = 0;
  localparam int PES_B  = 1;
  localparam int PSS_B  = 2;
  localparam int POCI_B = 3;
  localparam int PRS_B  = 4;
  localparam int PPS_B  = 8;
  localparam int LSDA_B = 9;
  localparam int CHG_LSB = 16;
  localparam int NUM_CHG = 5;
  localparam int CH_CONN = 0;
  localparam int CH_EN   = 1;
  localparam int CH_SUSP = 2;
  localparam int CH_OC   = 3;
  localparam int CH_RST  = 4;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RESET,
    SQ_RESUME,
    SQ_EOP,
    SQ_RESYNC
  } seq_state_e;
endpackage

// File: rtl/rhp_ms_tick.sv
module rhp_ms_tick #(
  parameter int CLKS_PER_MS = 48000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = at_last && !restart_i;

  always_comb begin
    if (restart_i || at_last) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rhp_seq.sv
module rhp_seq
  import rhp_pkg::*;
#(
  parameter int RESET_MS  = 10,
  parameter int RESUME_MS = 20,
  parameter int EOP_MS    = 1,
  parameter int RESYNC_MS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_reset_i,
  input  logic start_resume_i,
  input  logic abort_i,
  output logic in_reset_o,
  output logic in_resume_o,
  output logic reset_done_o,
  output logic resume_done_o
);
  localparam int MAXA = (RESET_MS > RESUME_MS) ? RESET_MS : RESUME_MS;
  localparam int MAXB = (EOP_MS > RESYNC_MS) ? EOP_MS : RESYNC_MS;
  localparam int MAXL = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int MSW  = $clog2(MAXL + 1);

  seq_state_e     state_q, state_d;
  logic [MSW-1:0] ms_q, ms_d, phase_len;
  logic           last, hold;

  always_comb begin
    case (state_q)
      SQ_RESET:  phase_len = MSW'(RESET_MS);
      SQ_RESUME: phase_len = MSW'(RESUME_MS);
      SQ_EOP:    phase_len = MSW'(EOP_MS);
      SQ_RESYNC: phase_len = MSW'(RESYNC_MS);
      default:   phase_len = MSW'(1);
    endcase
  end

  assign last = (ms_q == phase_len - 1'b1);
  assign hold = abort_i || start_reset_i;

  always_comb begin
    state_d = state_q;
    ms_d    = ms_q;
    if (abort_i) begin
      state_d = SQ_IDLE;
      ms_d    = '0;
    end else if (start_reset_i) begin
      state_d = SQ_RESET;
      ms_d    = '0;
    end else if (start_resume_i) begin
      state_d = SQ_RESUME;
      ms_d    = '0;
    end else if (tick_i && state_q != SQ_IDLE) begin
      if (last) begin
        ms_d = '0;
        case (state_q)
          SQ_RESUME: state_d = SQ_EOP;
          SQ_EOP:    state_d = SQ_RESYNC;
          default:   state_d = SQ_IDLE;
        endcase
      end else begin
        ms_d = ms_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ms_q    <= '0;
    end else begin
      state_q <= state_d;
      ms_q    <= ms_d;
    end
  end

  assign in_reset_o    = (state_q == SQ_RESET);
  assign in_resume_o   = (state_q == SQ_RESUME) || (state_q == SQ_EOP) || (state_q == SQ_RESYNC);
  assign reset_done_o  = !hold && tick_i && last && (state_q == SQ_RESET);
  assign resume_done_o = !hold && tick_i && last && (state_q == SQ_RESYNC);

  // R8: the end-of-packet phase is only reached from the resume pulse
  assert_eop_after_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_EOP) |-> ($past(state_q) == SQ_RESUME || $past(state_q) == SQ_EOP));
  assert_resync_after_eop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_RESYNC) |-> ($past(state_q) == SQ_EOP || $past(state_q) == SQ_RESYNC));
endmodule

// File: rtl/rhp_chg_flag.sv
module rhp_chg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wclr_i,
  input  logic hclr_i,
  output logic flag_o
);
  logic flag_d;

  always_comb begin
    if (set_i)                flag_d = 1'b1;
    else if (wclr_i || hclr_i) flag_d = 1'b0;
    else                      flag_d = flag_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_d;
  end

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wclr_i && !set_i) |=> !flag_o);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !wclr_i && !hclr_i) |=> $stable(flag_o));
endmodule

// File: rtl/rhp_port_status.sv
module rhp_port_status
  import rhp_pkg::*;
#(
  parameter int CLKS_PER_MS = 48000,
  parameter int RESET_MS    = 10,
  parameter int RESUME_MS   = 20,
  parameter int EOP_MS      = 1,
  parameter int RESYNC_MS   = 3,
  parameter bit OC_PER_PORT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        dev_connect_i,
  input  logic        dev_low_speed_i,
  input  logic        port_power_i,
  input  logic        over_current_i,
  input  logic        en_loss_i,
  input  logic        resume_req_i,
  output logic [31:0] status_o,
  output logic [4:0]  chg_o
);
  logic ccs_q, pps_q, lsda_q, poci_q, pes_q, pss_q;
  logic ccs_d, pps_d, lsda_d, poci_d, pes_d, pss_d;
  logic conn_ok, tick, in_reset, in_resume, reset_done, resume_done;
  logic start_reset, start_resume, suspend_req, abort, hw_drop, busy;
  logic wr_clr_en, wr_set_en, wr_susp, wr_resume, wr_reset;
  logic [NUM_CHG-1:0] chg_set, chg_wclr, chg_hclr, chg_q;
  logic unused_wr;

  assign wr_clr_en = wr_en_i & wr_data_i[CCS_B];
  assign wr_set_en = wr_en_i & wr_data_i[PES_B];
  assign wr_susp   = wr_en_i & wr_data_i[PSS_B];
  assign wr_resume = wr_en_i & wr_data_i[POCI_B];
  assign wr_reset  = wr_en_i & wr_data_i[PRS_B];
  assign chg_wclr  = {NUM_CHG{wr_en_i}} & wr_data_i[CHG_LSB +: NUM_CHG];
  assign unused_wr = ^{wr_data_i[31:CHG_LSB+NUM_CHG], wr_data_i[CHG_LSB-1:PRS_B+1]};

  assign conn_ok      = ccs_q & pps_q;
  assign busy         = in_reset | in_resume;
  assign start_reset  = wr_reset & conn_ok;
  assign start_resume = conn_ok & pss_q & !busy & !wr_reset & (wr_resume | resume_req_i);
  assign suspend_req  = conn_ok & pes_q & !busy & !wr_reset & wr_susp;
  assign abort        = !conn_ok | (in_resume & !pes_q);
  assign hw_drop      = pes_q & (en_loss_i | (ccs_q & !dev_connect_i) | (pps_q & !port_power_i));

  rhp_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (start_reset | start_resume),
    .tick_o    (tick)
  );

  rhp_seq #(
    .RESET_MS (RESET_MS),
    .RESUME_MS(RESUME_MS),
    .EOP_MS   (EOP_MS),
    .RESYNC_MS(RESYNC_MS)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_i         (tick),
    .start_reset_i  (start_reset),
    .start_resume_i (start_resume),
    .abort_i        (abort),
    .in_reset_o     (in_reset),
    .in_resume_o    (in_resume),
    .reset_done_o   (reset_done),
    .resume_done_o  (resume_done)
  );

  always_comb begin
    ccs_d  = dev_connect_i;
    pps_d  = port_power_i;
    lsda_d = dev_connect_i & dev_low_speed_i;
    poci_d = over_current_i;

    pes_d = pes_q;
    if (reset_done)           pes_d = 1'b1;
    if (wr_set_en && ccs_q)   pes_d = 1'b1;
    if (wr_clr_en)            pes_d = 1'b0;
    if (hw_drop)              pes_d = 1'b0;

    pss_d = pss_q;
    if (suspend_req)                 pss_d = 1'b1;
    if (resume_done || reset_done)   pss_d = 1'b0;
    if (!pes_d)                      pss_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccs_q  <= 1'b0;
      pps_q  <= 1'b0;
      lsda_q <= 1'b0;
      poci_q <= 1'b0;
      pes_q  <= 1'b0;
      pss_q  <= 1'b0;
    end else begin
      ccs_q  <= ccs_d;
      pps_q  <= pps_d;
      lsda_q <= lsda_d;
      poci_q <= poci_d;
      pes_q  <= pes_d;
      pss_q  <= pss_d;
    end
  end

  always_comb begin
    chg_set          = '0;
    chg_hclr         = '0;
    chg_set[CH_CONN] = (ccs_q != dev_connect_i);
    chg_set[CH_EN]   = hw_drop;
    chg_set[CH_SUSP] = resume_done;
    chg_set[CH_OC]   = OC_PER_PORT && (poci_q != over_current_i);
    chg_set[CH_RST]  = reset_done;
    chg_hclr[CH_SUSP] = reset_done;
  end

  for (genvar g = 0; g < NUM_CHG; g++) begin : g_chg
    rhp_chg_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (chg_set[g]),
      .wclr_i (chg_wclr[g]),
      .hclr_i (chg_hclr[g]),
      .flag_o (chg_q[g])
    );
  end

  always_comb begin
    status_o                       = '0;
    status_o[CCS_B]                = ccs_q;
    status_o[PES_B]                = pes_q;
    status_o[PSS_B]                = pss_q;
    status_o[POCI_B]               = poci_q;
    status_o[PRS_B]                = in_reset;
    status_o[PPS_B]                = pps_q;
    status_o[LSDA_B]               = lsda_q;
    status_o[CHG_LSB +: NUM_CHG]   = chg_q;
  end
  assign chg_o = chg_q;

  assert_ccs_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ccs_q == $past(dev_connect_i)));
  assert_reset_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_q[CH_RST]) |-> (!in_reset && !pss_q));
  assert_start_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_reset) |-> $past(conn_ok));
  assert_pssc_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_q[CH_RST]) |-> !chg_q[CH_SUSP]);
  assert_pesc_hw_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_q[CH_EN]) |-> ($past(pes_q) && !pes_q));
  assert_ocic_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_q[CH_OC]) |-> (poci_q != $past(poci_q)));
endmodule

// File: tb/test_rhp_port_status.sv
module test_rhp_port_status;
  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 4;
  localparam int T_RST      = 10 * CPM;
  localparam int T_RES      = 24 * CPM;
  localparam logic [31:0] RSV_MASK = 32'hFFE0_FCE0;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en_i;
  logic [31:0] wr_data_i;
  logic        dev_connect_i, dev_low_speed_i, port_power_i;
  logic        over_current_i, en_loss_i, resume_req_i;
  logic [31:0] status_o;
  logic [4:0]  chg_o;

  typedef struct {
    int          due;
    bit          sel;
    logic [31:0] mask;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    b;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rhp_port_status #(.CLKS_PER_MS(CPM)) i_rhp_port_status (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en_i         (wr_en_i),
    .wr_data_i       (wr_data_i),
    .dev_connect_i   (dev_connect_i),
    .dev_low_speed_i (dev_low_speed_i),
    .port_power_i    (port_power_i),
    .over_current_i  (over_current_i),
    .en_loss_i       (en_loss_i),
    .resume_req_i    (resume_req_i),
    .status_o        (status_o),
    .chg_o           (chg_o)
  );

  // monitor: compares queued expectations at their due cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [31:0] act;
        act = sb[i].sel ? {27'b0, chg_o} : status_o;
        n_chk++;
        if ((act & sb[i].mask) !== sb[i].exp) begin
          n_fail++;
          $display("FAIL %s cycle %0d: actual %h expected %h (mask %h)",
                   sb[i].req, cyc, act & sb[i].mask, sb[i].exp, sb[i].mask);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(input int due, input logic [31:0] m, input logic [31:0] v,
                           input string r, input bit sel = 1'b0);
    item_t it;
    it.due = due; it.sel = sel; it.mask = m; it.exp = v; it.req = r;
    sb.push_back(it);
  endtask

  // driver: one step per cycle, b is the edge that samples the new inputs
  task automatic step();
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0; en_loss_i = 1'b0; resume_req_i = 1'b0;
    b = cyc + 1;
  endtask

  task automatic write(input logic [31:0] d);
    step();
    wr_en_i = 1'b1; wr_data_i = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    dev_connect_i = 1'b0; dev_low_speed_i = 1'b0; port_power_i = 1'b0;
    over_current_i = 1'b0; en_loss_i = 1'b0; resume_req_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step();
    expect_at(b, 32'hFFFF_FFFF, 32'h0, "R1");
    expect_at(b, 32'h1F, 32'h0, "R1", 1'b1);

    step(); port_power_i = 1'b1;                         // R4 power
    expect_at(b, 32'h100, 32'h100, "R4");

    write(32'h10);                                       // R6 not connected
    expect_at(b, 32'h10, 32'h0, "R6");
    expect_at(b + 2, 32'h10, 32'h0, "R6");
    idle(3);

    step(); dev_connect_i = 1'b1; dev_low_speed_i = 1'b1; // R4 connect
    expect_at(b, 32'h0001_0201, 32'h0001_0201, "R4");
    expect_at(b, 32'h1F, 32'h01, "R13", 1'b1);

    write(32'h0);                                        // R3 zero write
    expect_at(b, 32'h0001_0000, 32'h0001_0000, "R3");
    write(32'h0001_0000);                                // R3 clear
    expect_at(b, 32'h0001_0000, 32'h0, "R3");

    write(32'h10);                                       // R5 reset
    expect_at(b, 32'h10, 32'h10, "R5");
    expect_at(b + T_RST - 1, 32'h0010_0012, 32'h10, "R5");
    expect_at(b + T_RST, 32'h0010_0016, 32'h0010_0002, "R5");
    expect_at(b + T_RST, RSV_MASK, 32'h0, "R2");
    idle(T_RST + 2);

    write(32'h4);                                        // R7 suspend
    expect_at(b, 32'h4, 32'h4, "R7");
    idle(2);

    write(32'h8);                                        // R8 resume by write
    expect_at(b + T_RES - 1, 32'h0004_0004, 32'h4, "R8");
    expect_at(b + T_RES, 32'h0004_0004, 32'h0004_0000, "R8");
    expect_at(b + 30, RSV_MASK, 32'h0, "R2");
    idle(T_RES + 2);

    write(32'h0010_0000);                                // clear reset flag
    expect_at(b, 32'h0010_0000, 32'h0, "R3");
    write(32'h4);
    expect_at(b, 32'h4, 32'h4, "R7");
    write(32'h10);                                       // R9 reset clears suspend flag
    expect_at(b + T_RST - 1, 32'h0004_0000, 32'h0004_0000, "R9");
    expect_at(b + T_RST, 32'h0014_0004, 32'h0010_0000, "R9");
    idle(T_RST + 2);

    write(32'h4);
    expect_at(b, 32'h4, 32'h4, "R7");
    step(); resume_req_i = 1'b1;                         // R8 resume by request
    expect_at(b + T_RES - 1, 32'h0004_0004, 32'h4, "R8");
    expect_at(b + T_RES, 32'h0004_0004, 32'h0004_0000, "R8");
    idle(T_RES + 2);

    step(); over_current_i = 1'b1;                       // R11
    expect_at(b, 32'h0008_0008, 32'h0008_0008, "R11");
    step(); over_current_i = 1'b0; wr_en_i = 1'b1; wr_data_i = 32'h0008_0000; // R12
    expect_at(b, 32'h0008_0008, 32'h0008_0000, "R12");
    write(32'h0008_0000);
    expect_at(b, 32'h0008_0000, 32'h0, "R3");

    write(32'h1);                                        // R10 software clear
    expect_at(b, 32'h0002_0002, 32'h0, "R10");
    write(32'h2);                                        // R10 software set
    expect_at(b, 32'h0002_0002, 32'h2, "R10");
    step(); en_loss_i = 1'b1;                            // R10 hardware loss
    expect_at(b, 32'h0002_0002, 32'h0002_0000, "R10");
    write(32'h0002_0000);
    expect_at(b, 32'h0002_0000, 32'h0, "R3");
    write(32'h2);
    expect_at(b, 32'h2, 32'h2, "R10");
    step(); dev_connect_i = 1'b0;                        // detach
    expect_at(b, 32'h0003_0203, 32'h0003_0000, "R10");
    expect_at(b, 32'h1F, 32'h17, "R13", 1'b1);

    write(32'h10);                                       // R6 detached
    expect_at(b, 32'h10, 32'h0, "R6");
    expect_at(b + 2, 32'h10, 32'h0, "R6");
    write(32'h4);
    expect_at(b, 32'h4, 32'h0, "R6");
    expect_at(b, RSV_MASK, 32'h0, "R2");
    idle(5);

    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule